// File: doc/BRIEF.md
# Command-Accepting Dataway Slave with Firmware Handshake

This block sits between a crate dataway and a slow embedded processor. Nearly every command that arrives on the dataway is handed to the processor's firmware for interpretation. Dedicated logic answers only three functions itself: an attention test, an attention clear and a master reset. The response bit is used purely as a handshake. A command is answered with Q=1 only when the firmware has declared itself ready. For a read, the incoming command must also match a code that the firmware loaded in advance. Each acceptance withdraws readiness, so later commands are refused until the firmware arms the slave again.

A dataway cycle is a strobe held high for one or more clocks, with a function code, a subaddress and write data. The slave takes one decision on the first clock of the strobe. It then holds its response and read data steady until the strobe falls. Together, the function (upper five bits) and the subaddress (lower three bits) form an 8-bit command code. The processor side sees the accepted command, the accepted write word, the code of the most recent cycle, an event flag and the ready bit. It drives pulses to arm readiness, raise attention and clear the event flag, plus load strobes for the expected read code and the read word.

The controller has two states. ST_IDLE waits for a strobe. ST_RESPOND holds the response. There are three transitions: START (ST_IDLE to ST_RESPOND when the strobe is seen), HOLD (stay in ST_RESPOND while the strobe stays high) and END (ST_RESPOND to ST_IDLE when the strobe falls).

Top module: `dws_slave`

## Requirements
- R1: After rst_n low, dw_q, dw_rdata, dw_attn, cpu_ready, cpu_event, cpu_op and cpu_data are all zero.
- R2: A write (function bits [4:3] = 2'b10) that arrives while ready is set gets dw_q=1 for the strobe. cpu_op captures the command code {function, subaddress} with function in bits [7:3] and subaddress in [2:0]. cpu_data captures dw_wdata, and ready clears.
- R3: A control function (function bit [3] = 1, other than the three dedicated codes) that arrives while ready is set gets dw_q=1. cpu_op captures its code, cpu_data keeps its value and ready clears.
- R4: A write or control that arrives while ready is clear gets dw_q=0 and leaves cpu_op and cpu_data unchanged.
- R5: A read (function bits [4:3] = 2'b00) gets dw_q=1 only when ready is set and its command code equals the preloaded expected code. It then drives the preloaded word on dw_rdata for the whole strobe, and ready clears.
- R6: A refused read (no match, or not ready) gets dw_q=0 and dw_rdata=0, and ready is left unchanged.
- R7: cpu_seen holds the command code of the latest dataway cycle, whether or not that cycle was accepted.
- R8: cpu_event is set by every dataway cycle other than master reset. It is cleared by a cpu_evt_clr pulse. When both happen in the same clock, the set wins.
- R9: A cpu_attn_set pulse raises dw_attn, and dw_attn stays high until cleared.
- R10: Function 8 (attention test) answers dw_q equal to dw_attn, whatever the ready bit. It changes neither ready nor attention.
- R11: Function 10 (attention clear) answers dw_q=1, clears dw_attn and leaves ready unchanged.
- R12: Function 9 (master reset) answers dw_q=1. In the clock its strobe is seen, it clears ready, attention, the event flag, cpu_op and cpu_data.
- R13: One decision is taken per strobe. dw_q and dw_rdata stay stable while the strobe is held, and both are zero once the strobe has been low for a clock.
- R14: A cpu_set_ready pulse sets cpu_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dw_strobe | input | 1 | Dataway cycle strobe addressed to this slave |
| dw_func | input | 5 | Function code |
| dw_sub | input | 3 | Subaddress |
| dw_wdata | input | 16 | Write data |
| dw_rdata | output | 16 | Read data, valid during the strobe |
| dw_q | output | 1 | Handshake response |
| dw_attn | output | 1 | Attention request to the parent |
| cpu_op | output | 8 | Last accepted command code |
| cpu_data | output | 16 | Last accepted write word |
| cpu_seen | output | 8 | Code of the latest dataway cycle |
| cpu_ready | output | 1 | Ready status bit |
| cpu_event | output | 1 | Dataway cycle event flag |
| cpu_set_ready | input | 1 | Pulse that arms readiness |
| cpu_attn_set | input | 1 | Pulse that raises attention |
| cpu_evt_clr | input | 1 | Pulse that clears the event flag |
| cpu_exp_we | input | 1 | Load strobe for the expected read code |
| cpu_exp_cmd | input | 8 | Expected read command code |
| cpu_pre_we | input | 1 | Load strobe for the read word |
| cpu_pre_data | input | 16 | Preloaded read word |

## Verification
The bench sends a second command straight after an accepted one. A slave that failed to withdraw readiness would answer Q=1 again and overwrite the captured command. It sends reads whose code is off by one subaddress. A decoder that compares only the function field would acknowledge them and leak the preloaded word. It holds a strobe for several clocks. A design that decides on every clock would accept the command, clear ready and then refuse its own cycle partway through. It also checks the case where the event clear and a new cycle land in the same clock, and it confirms that a master reset clears every firmware-visible register at once.

// File: rtl/dws_pkg.sv
package dws_pkg;
    localparam int FUNC_W = 5;
    localparam int SUB_W  = 3;
    localparam int CMD_W  = FUNC_W + SUB_W;
    localparam int DATA_W = 16;

    localparam logic [FUNC_W-1:0] FN_TEST  = FUNC_W'(8);
    localparam logic [FUNC_W-1:0] FN_RESET = FUNC_W'(9);
    localparam logic [FUNC_W-1:0] FN_CLEAR = FUNC_W'(10);

    typedef enum logic [2:0] {
        K_READ, K_WRITE, K_CTRL, K_TEST, K_CLEAR, K_RESET
    } kind_e;

    typedef enum logic {
        ST_IDLE, ST_RESPOND
    } state_e;
endpackage

// File: rtl/dws_decode.sv
module dws_decode
    import dws_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    input  logic [SUB_W-1:0]  sub,
    input  logic              ready,
    input  logic              attn,
    input  logic [CMD_W-1:0]  exp_cmd,
    output kind_e             kind,
    output logic              accept,
    output logic              q
);
    logic [CMD_W-1:0] cmd;
    logic [1:0]       fclass;

    assign cmd    = {func, sub};
    assign fclass = func[FUNC_W-1 -: 2];

    always_comb begin
        kind   = K_CTRL;
        accept = 1'b0;
        q      = 1'b0;
        if (func == FN_TEST) begin
            kind = K_TEST;
            q    = attn;
        end else if (func == FN_CLEAR) begin
            kind = K_CLEAR;
            q    = 1'b1;
        end else if (func == FN_RESET) begin
            kind = K_RESET;
            q    = 1'b1;
        end else begin
            unique case (fclass)
                2'b00: begin
                    kind   = K_READ;
                    accept = ready && (cmd == exp_cmd);
                end
                2'b10: begin
                    kind   = K_WRITE;
                    accept = ready;
                end
                default: begin
                    kind   = K_CTRL;
                    accept = ready;
                end
            endcase
            q = accept;
        end
    end

    // R5: firmware-bound acceptance never happens without readiness
    always_comb begin
        if (accept) assert_accept_needs_ready_R5: assert (ready);
    end
endmodule

// File: rtl/dws_cpu_regs.sv
module dws_cpu_regs
    import dws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  kind_e             dec_kind,
    input  logic              dec_accept,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_ready,
    input  logic              attn_set,
    input  logic              evt_clr,
    input  logic              exp_we,
    input  logic [CMD_W-1:0]  exp_in,
    input  logic              pre_we,
    input  logic [DATA_W-1:0] pre_in,
    output logic              ready,
    output logic              attn,
    output logic              evt,
    output logic [CMD_W-1:0]  op_reg,
    output logic [DATA_W-1:0] data_reg,
    output logic [CMD_W-1:0]  seen,
    output logic [CMD_W-1:0]  exp_cmd,
    output logic [DATA_W-1:0] pre_data
);
    logic do_reset, do_accept;

    assign do_reset  = start && (dec_kind == K_RESET);
    assign do_accept = start && dec_accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ready <= 1'b0;
        else if (do_reset)  ready <= 1'b0;
        else if (do_accept) ready <= 1'b0;
        else if (set_ready) ready <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) attn <= 1'b0;
        else if (do_reset || (start && dec_kind == K_CLEAR)) attn <= 1'b0;
        else if (attn_set) attn <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        evt <= 1'b0;
        else if (do_reset) evt <= 1'b0;
        else if (start)    evt <= 1'b1;
        else if (evt_clr)  evt <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_reg   <= '0;
            data_reg <= '0;
        end else if (do_reset) begin
            op_reg   <= '0;
            data_reg <= '0;
        end else if (do_accept) begin
            op_reg <= cmd;
            if (dec_kind == K_WRITE) data_reg <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     seen <= '0;
        else if (start) seen <= cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_cmd  <= '0;
            pre_data <= '0;
        end else begin
            if (exp_we) exp_cmd  <= exp_in;
            if (pre_we) pre_data <= pre_in;
        end
    end

    assert_accept_clears_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dec_accept) |=> !ready);

    assert_lockout_keeps_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ready && (dec_kind == K_WRITE || dec_kind == K_CTRL))
            |=> ($stable(op_reg) && $stable(data_reg)));

    assert_cycle_sets_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dec_kind != K_RESET) |=> evt);

    assert_test_keeps_attn_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dec_kind == K_TEST && !attn_set) |=> $stable(attn));

    assert_master_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dec_kind == K_RESET)
            |=> (!ready && !attn && !evt && op_reg == '0 && data_reg == '0));
endmodule

// File: rtl/dws_slave.sv
module dws_slave
    import dws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dw_strobe,
    input  logic [FUNC_W-1:0] dw_func,
    input  logic [SUB_W-1:0]  dw_sub,
    input  logic [DATA_W-1:0] dw_wdata,
    output logic [DATA_W-1:0] dw_rdata,
    output logic              dw_q,
    output logic              dw_attn,
    output logic [CMD_W-1:0]  cpu_op,
    output logic [DATA_W-1:0] cpu_data,
    output logic [CMD_W-1:0]  cpu_seen,
    output logic              cpu_ready,
    output logic              cpu_event,
    input  logic              cpu_set_ready,
    input  logic              cpu_attn_set,
    input  logic              cpu_evt_clr,
    input  logic              cpu_exp_we,
    input  logic [CMD_W-1:0]  cpu_exp_cmd,
    input  logic              cpu_pre_we,
    input  logic [DATA_W-1:0] cpu_pre_data
);
    state_e            state, state_nx;
    logic              start;
    kind_e             dec_kind;
    logic              dec_accept, dec_q;
    logic [CMD_W-1:0]  exp_cmd;
    logic [DATA_W-1:0] pre_data;
    logic              q_r;
    logic [DATA_W-1:0] rdata_r;

    assign start = (state == ST_IDLE) && dw_strobe;

    dws_decode u_decode (
        .func    (dw_func),
        .sub     (dw_sub),
        .ready   (cpu_ready),
        .attn    (dw_attn),
        .exp_cmd (exp_cmd),
        .kind    (dec_kind),
        .accept  (dec_accept),
        .q       (dec_q)
    );

    dws_cpu_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dec_kind   (dec_kind),
        .dec_accept (dec_accept),
        .cmd        ({dw_func, dw_sub}),
        .wdata      (dw_wdata),
        .set_ready  (cpu_set_ready),
        .attn_set   (cpu_attn_set),
        .evt_clr    (cpu_evt_clr),
        .exp_we     (cpu_exp_we),
        .exp_in     (cpu_exp_cmd),
        .pre_we     (cpu_pre_we),
        .pre_in     (cpu_pre_data),
        .ready      (cpu_ready),
        .attn       (dw_attn),
        .evt        (cpu_event),
        .op_reg     (cpu_op),
        .data_reg   (cpu_data),
        .seen       (cpu_seen),
        .exp_cmd    (exp_cmd),
        .pre_data   (pre_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions START, HOLD, END
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (dw_strobe)  state_nx = ST_RESPOND;
            ST_RESPOND: if (!dw_strobe) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // registered response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r     <= 1'b0;
            rdata_r <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (dw_strobe) begin
                    q_r     <= dec_q;
                    rdata_r <= (dec_kind == K_READ && dec_accept) ? pre_data : '0;
                end
                ST_RESPOND: if (!dw_strobe) begin
                    q_r     <= 1'b0;
                    rdata_r <= '0;
                end
                default: begin
                    q_r     <= 1'b0;
                    rdata_r <= '0;
                end
            endcase
        end
    end

    assign dw_q     = q_r;
    assign dw_rdata = rdata_r;

    assert_q_low_after_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !dw_strobe |=> (!dw_q && dw_rdata == '0));

    assert_response_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESPOND && dw_strobe) |=> ($stable(dw_q) && $stable(dw_rdata)));

    assert_refused_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESPOND && !dw_q) |-> dw_rdata == '0);
endmodule

// File: tb/test_dws_slave.sv
module test_dws_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dw_strobe = 1'b0;
    logic [4:0]  dw_func = '0;
    logic [2:0]  dw_sub = '0;
    logic [15:0] dw_wdata = '0;
    logic [15:0] dw_rdata;
    logic        dw_q, dw_attn;
    logic [7:0]  cpu_op, cpu_seen;
    logic [15:0] cpu_data;
    logic        cpu_ready, cpu_event;
    logic        cpu_set_ready = 1'b0, cpu_attn_set = 1'b0, cpu_evt_clr = 1'b0;
    logic        cpu_exp_we = 1'b0, cpu_pre_we = 1'b0;
    logic [7:0]  cpu_exp_cmd = '0;
    logic [15:0] cpu_pre_data = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dws_slave i_dws_slave (
        .clk(clk), .rst_n(rst_n), .dw_strobe(dw_strobe), .dw_func(dw_func),
        .dw_sub(dw_sub), .dw_wdata(dw_wdata), .dw_rdata(dw_rdata), .dw_q(dw_q),
        .dw_attn(dw_attn), .cpu_op(cpu_op), .cpu_data(cpu_data), .cpu_seen(cpu_seen),
        .cpu_ready(cpu_ready), .cpu_event(cpu_event), .cpu_set_ready(cpu_set_ready),
        .cpu_attn_set(cpu_attn_set), .cpu_evt_clr(cpu_evt_clr), .cpu_exp_we(cpu_exp_we),
        .cpu_exp_cmd(cpu_exp_cmd), .cpu_pre_we(cpu_pre_we), .cpu_pre_data(cpu_pre_data)
    );

    typedef struct packed {
        logic [4:0]  f;
        logic [2:0]  a;
        logic [15:0] wd;
        logic        arm;
        logic [7:0]  exp_cmd;
        logic [15:0] pre;
        logic        exp_q;
        logic [15:0] exp_rd;
        logic        exp_rdy;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd16, 3'd1, 16'h1234, 1'b1, 8'h00, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R2 write
        '{5'd16, 3'd1, 16'h1234, 1'b0, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R4 write unarmed
        '{5'd24, 3'd2, 16'h0000, 1'b1, 8'h00, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R3 control
        '{5'd0,  3'd3, 16'h0000, 1'b1, 8'h03, 16'hBEEF, 1'b1, 16'hBEEF, 1'b0}, // R5 read match
        '{5'd0,  3'd3, 16'h0000, 1'b1, 8'h04, 16'hBEEF, 1'b0, 16'h0000, 1'b1}, // R6 read mismatch
        '{5'd2,  3'd0, 16'h0000, 1'b0, 8'h10, 16'h7777, 1'b0, 16'h0000, 1'b0}, // R6 read unarmed
        '{5'd1,  3'd7, 16'h0000, 1'b1, 8'h0F, 16'hA5A5, 1'b1, 16'hA5A5, 1'b0}, // R5 read match
        '{5'd8,  3'd0, 16'h0000, 1'b1, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R10 test, no attn
        '{5'd10, 3'd4, 16'h0000, 1'b1, 8'h00, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R11 clear
        '{5'd20, 3'd5, 16'h4321, 1'b1, 8'h00, 16'h0000, 1'b1, 16'h0000, 1'b0}  // R2 write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic pulse_ready();
        @(negedge clk); cpu_set_ready = 1'b1;
        @(negedge clk); cpu_set_ready = 1'b0;
    endtask

    task automatic pulse_attn();
        @(negedge clk); cpu_attn_set = 1'b1;
        @(negedge clk); cpu_attn_set = 1'b0;
    endtask

    task automatic pulse_evt_clr();
        @(negedge clk); cpu_evt_clr = 1'b1;
        @(negedge clk); cpu_evt_clr = 1'b0;
    endtask

    task automatic preload(input logic [7:0] e, input logic [15:0] d);
        @(negedge clk);
        cpu_exp_we = 1'b1; cpu_exp_cmd = e; cpu_pre_we = 1'b1; cpu_pre_data = d;
        @(negedge clk);
        cpu_exp_we = 1'b0; cpu_pre_we = 1'b0;
    endtask

    task automatic dw_cycle(input logic [4:0] f, input logic [2:0] a, input logic [15:0] wd,
                            input int hold, output logic q1, output logic [15:0] rd1,
                            output bit steady, output logic q_end, output logic [15:0] rd_end);
        @(negedge clk);
        dw_strobe = 1'b1; dw_func = f; dw_sub = a; dw_wdata = wd;
        @(negedge clk);
        q1 = dw_q; rd1 = dw_rdata; steady = 1'b1;
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            if (dw_q !== q1 || dw_rdata !== rd1) steady = 1'b0;
        end
        dw_strobe = 1'b0;
        @(negedge clk);
        q_end = dw_q; rd_end = dw_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        logic q1, qe;
        logic [15:0] rd1, rde;
        bit st;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 q", dw_q, 0);
        check("R1 rdata", dw_rdata, 0);
        check("R1 attn", dw_attn, 0);
        check("R1 ready", cpu_ready, 0);
        check("R1 event", cpu_event, 0);
        check("R1 op", cpu_op, 0);
        check("R1 data", cpu_data, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            dw_cycle(5'd9, 3'd0, 16'h0, 1, q1, rd1, st, qe, rde);
            preload(VECS[i].exp_cmd, VECS[i].pre);
            if (VECS[i].arm) pulse_ready();
            dw_cycle(VECS[i].f, VECS[i].a, VECS[i].wd, 2, q1, rd1, st, qe, rde);
            check($sformatf("R5 R2 vec%0d q", i), q1, VECS[i].exp_q);
            check($sformatf("R6 vec%0d rdata", i), rd1, VECS[i].exp_rd);
            check($sformatf("R4 vec%0d ready after", i), cpu_ready, VECS[i].exp_rdy);
            check($sformatf("R7 vec%0d seen", i), cpu_seen, {VECS[i].f, VECS[i].a});
            check($sformatf("R13 vec%0d end", i), {15'd0, qe} | {16'd0, rde}, 0);
        end

        // R14 and R2: write captures code and data
        dw_cycle(5'd9, 3'd0, 16'h0, 1, q1, rd1, st, qe, rde);
        pulse_ready();
        check("R14 ready set", cpu_ready, 1);
        dw_cycle(5'd16, 3'd2, 16'h5A5A, 1, q1, rd1, st, qe, rde);
        check("R2 q", q1, 1);
        check("R2 op", cpu_op, 8'h82);
        check("R2 data", cpu_data, 16'h5A5A);
        // R4 lockout
        dw_cycle(5'd17, 3'd0, 16'h1111, 1, q1, rd1, st, qe, rde);
        check("R4 q", q1, 0);
        check("R4 op", cpu_op, 8'h82);
        check("R4 data", cpu_data, 16'h5A5A);
        check("R7 seen on refusal", cpu_seen, 8'h88);
        // R3 control keeps data
        pulse_ready();
        dw_cycle(5'd26, 3'd1, 16'hFFFF, 1, q1, rd1, st, qe, rde);
        check("R3 q", q1, 1);
        check("R3 op", cpu_op, 8'hD1);
        check("R3 data", cpu_data, 16'h5A5A);
        check("R3 ready", cpu_ready, 0);

        // R8 event flag
        check("R8 event set", cpu_event, 1);
        pulse_evt_clr();
        check("R8 event clr", cpu_event, 0);
        @(negedge clk);
        dw_strobe = 1'b1; dw_func = 5'd17; dw_sub = 3'd0; cpu_evt_clr = 1'b1;
        @(negedge clk);
        cpu_evt_clr = 1'b0;
        check("R8 set wins", cpu_event, 1);
        dw_strobe = 1'b0;
        @(negedge clk);

        // R9 R10 R11 attention
        pulse_attn();
        check("R9 attn", dw_attn, 1);
        dw_cycle(5'd8, 3'd6, 16'h0, 1, q1, rd1, st, qe, rde);
        check("R10 test q", q1, 1);
        check("R10 attn kept", dw_attn, 1);
        check("R10 ready kept", cpu_ready, 0);
        pulse_ready();
        dw_cycle(5'd10, 3'd0, 16'h0, 1, q1, rd1, st, qe, rde);
        check("R11 clear q", q1, 1);
        check("R11 attn", dw_attn, 0);
        check("R11 ready kept", cpu_ready, 1);
        dw_cycle(5'd8, 3'd0, 16'h0, 1, q1, rd1, st, qe, rde);
        check("R10 test q low", q1, 0);

        // R12 master reset clears all within one clock
        dw_cycle(5'd16, 3'd3, 16'h9999, 1, q1, rd1, st, qe, rde);
        pulse_ready();
        pulse_attn();
        @(negedge clk);
        dw_strobe = 1'b1; dw_func = 5'd9; dw_sub = 3'd2;
        @(negedge clk);
        check("R12 q", dw_q, 1);
        check("R12 ready", cpu_ready, 0);
        check("R12 attn", dw_attn, 0);
        check("R12 event", cpu_event, 0);
        check("R12 op", cpu_op, 0);
        check("R12 data", cpu_data, 0);
        dw_strobe = 1'b0;
        @(negedge clk);

        // R13 long strobe: one decision, held response
        preload(8'h05, 16'hC0DE);
        pulse_ready();
        dw_cycle(5'd0, 3'd5, 16'h0, 6, q1, rd1, st, qe, rde);
        check("R13 q held", q1, 1);
        check("R13 rdata held", rd1, 16'hC0DE);
        check("R13 stable", st, 1);
        check("R13 q end", qe, 0);
        check("R13 rdata end", rde, 0);
        check("R5 ready cleared", cpu_ready, 0);

        done = 1'b1;
        report();
    end
endmodule